// File: doc/BRIEF.md
# SD Card Command Issue Engine

This block runs the command half of an SD card host controller for a single slot. Software writes a 32-bit argument and a load value for the response timer, then writes a command word that carries the command index and the type flags. The engine builds a 48-bit command frame, appends a CRC7, and shifts the frame out on the CMD line at one bit per clock. It then captures a short (48-bit) or long (136-bit) response, or none. A command that expects a response starts a timer as soon as the end bit has gone out. If the card stays silent for too long, the engine flags a timeout.

A start flag in the command word stays set while the command is running and drops when it is done. A separate fail flag reports any error. Error and event conditions collect in a status register whose bits are cleared by writing one to them. The data path sits outside this block. The engine gives it the read, write and busy-wait flags of the active command, and accepts its event pulses into the status register. For a command with busy-wait, the engine keeps the command open after the response until the card lets DAT0 go high.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset every register reads zero, cmdOe is 0 and cmdOut is 1.
- R2: The word address map is 0 command, 1 argument, 2 timeout load value, 3 status, and 4 to 7 the response words 0 to 3. A write to the command word with bit 15 set, while the engine is idle, starts a command. It latches the flags and clears the fail bit (bit 14). Bit 15 reads 1 from the next cycle until the command finishes. A command-word write with bit 15 clear has no effect.
- R3: In the command word, bits 5:0 hold the index, bit 6 read, bit 7 write, bit 9 long response, bit 10 no response and bit 11 busy-wait. The frame is 48 bits sent MSB first, one per clock, with cmdOe high for exactly those cycles. It is made of a 0 start bit, a 1 direction bit, the index, the argument, a CRC7 (x^7+x^3+1) over the first 40 bits, and a 1 end bit.
- R4: A no-response command finishes on the clock edge that follows the cycle carrying the end bit. Its bit 15 reads 0 one cycle after the last frame bit.
- R5: The timer is loaded with T from the timeout register when the end bit goes out. A response start bit (cmdIn low) is accepted in any of the first T+1 cycles after the end bit. If none arrives in that window, status bit 6 and the fail bit are set.
- R6: A short response is 48 bits long, and its bits 39:8 are stored in response word 0.
- R7: For a short response, the CRC7 is recomputed over the first 40 bits and compared with bits 7:1. A mismatch sets status bit 4 and the fail bit.
- R8: A long response is 136 bits long, and its bits 127:0 are stored with word 0 holding 31:0 and word 3 holding 127:96.
- R9: With busy-wait set, bit 15 stays 1 after the response until dat0In is high. Status bit 10 is then set and the command finishes.
- R10: A command with both long response and busy-wait is rejected. No frame is sent, bit 15 is not set and the fail bit is set.
- R11: A command-word write while a command is active is ignored.
- R12: Status bits clear on writing 1. The data-path event inputs dpEvent[0..4] set status bits 3, 5, 7, 8 and 9. A set in the same cycle as a clear wins.
- R13: xferRead, xferWrite and xferBusyWait show bits 6, 7 and 11 of the active command while bit 15 is 1, and read 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address (read and write) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| cmdIn | input | 1 | CMD line level from the pad |
| cmdOut | output | 1 | CMD line value to drive |
| cmdOe | output | 1 | CMD line drive enable |
| dat0In | input | 1 | DAT0 level, used for busy detection |
| dpEvent | input | 5 | Data-path event pulses that set status bits |
| xferRead | output | 1 | Active command has the read flag |
| xferWrite | output | 1 | Active command has the write flag |
| xferBusyWait | output | 1 | Active command has the busy-wait flag |

## Verification
The status register can be written by software and set by the engine or the data path in the same cycle. The bench provokes this by pulsing a data-path event on the same clock as a write-one-to-clear of that same bit. It expects the bit to survive while the other bits stay as they were. The start-bit window has the same kind of conflict: the timer reaches zero just as the card may pull CMD low. The bench places the response start exactly at cycle T, where it must be accepted, and at cycle T+1, where a timeout must win.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int ARG_W     = 32;
  localparam int IDX_W     = 6;
  localparam int CRC_W     = 7;
  localparam int CMD_LEN   = 48;
  localparam int RSP_SHORT = 48;
  localparam int RSP_LONG  = 136;
  localparam int RSP_W     = 128;
  localparam int STAT_W    = 11;

  // word addresses
  localparam int A_CMD  = 0;
  localparam int A_ARG  = 1;
  localparam int A_TOUT = 2;
  localparam int A_STAT = 3;

  // status bit positions
  localparam int S_FIFO  = 3;
  localparam int S_CRC7  = 4;
  localparam int S_CRC16 = 5;
  localparam int S_CTO   = 6;
  localparam int S_RWTO  = 7;
  localparam int S_SDIO  = 8;
  localparam int S_BLK   = 9;
  localparam int S_BUSY  = 10;

  typedef enum logic [2:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_RECV, ST_BUSY} state_t;

  typedef struct packed {
    logic accept;
    logic shiftTx;
    logic loadTimer;
    logic decTimer;
    logic startRx;
    logic shiftRx;
    logic storeResp;
    logic flagTimeout;
    logic flagCrc;
    logic flagBusy;
  } strobe_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:3], c[2] ^ fb, c[1:0], fb};
  endfunction
endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdWr,
  input  logic    reqStart,
  input  logic    reqLong,
  input  logic    reqBusy,
  input  logic    flagNoResp,
  input  logic    flagBusy,
  input  logic    txLast,
  input  logic    timerZero,
  input  logic    rxLast,
  input  logic    crcBad,
  input  logic    cmdIn,
  input  logic    dat0In,
  output strobe_t strb,
  output logic    newBit,
  output logic    failBit,
  output logic    sending
);
  state_t state, stNext;
  logic   newNext, failNext;

  always_comb begin
    strb     = '0;
    stNext   = state;
    newNext  = newBit;
    failNext = failBit;
    unique case (state)
      ST_IDLE: if (cmdWr && reqStart) begin
        strb.accept = 1'b1;
        if (reqLong && reqBusy) begin
          failNext = 1'b1;
        end else begin
          stNext   = ST_SEND;
          newNext  = 1'b1;
          failNext = 1'b0;
        end
      end
      ST_SEND: begin
        strb.shiftTx = 1'b1;
        if (txLast) begin
          if (flagNoResp) begin
            stNext  = ST_IDLE;
            newNext = 1'b0;
          end else begin
            stNext         = ST_WAIT;
            strb.loadTimer = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!cmdIn) begin
          strb.startRx = 1'b1;
          stNext       = ST_RECV;
        end else if (timerZero) begin
          strb.flagTimeout = 1'b1;
          failNext         = 1'b1;
          stNext           = ST_IDLE;
          newNext          = 1'b0;
        end else begin
          strb.decTimer = 1'b1;
        end
      end
      ST_RECV: begin
        strb.shiftRx = 1'b1;
        if (rxLast) begin
          strb.storeResp = 1'b1;
          if (crcBad) begin
            strb.flagCrc = 1'b1;
            failNext     = 1'b1;
            stNext       = ST_IDLE;
            newNext      = 1'b0;
          end else if (flagBusy) begin
            stNext = ST_BUSY;
          end else begin
            stNext  = ST_IDLE;
            newNext = 1'b0;
          end
        end
      end
      ST_BUSY: if (dat0In) begin
        strb.flagBusy = 1'b1;
        stNext        = ST_IDLE;
        newNext       = 1'b0;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      newBit  <= 1'b0;
      failBit <= 1'b0;
    end else begin
      state   <= stNext;
      newBit  <= newNext;
      failBit <= failNext;
    end
  end

  assign sending = (state == ST_SEND);

  // R10
  reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cmdWr && reqStart && reqLong && reqBusy)
      |=> (state == ST_IDLE && failBit && !newBit));

  // R2
  active_new_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> newBit);

  // R4
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(newBit) |-> ($past(state) != ST_SEND || $past(txLast)));
endmodule

// File: rtl/sdcmd_dp.sv
module sdcmd_dp
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int TOUT_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic              cmdIn,
  input  logic [4:0]        dpEvent,
  input  logic              newBit,
  input  logic              failBit,
  output logic              txBit,
  output logic              txLast,
  output logic              timerZero,
  output logic              rxLast,
  output logic              crcBad,
  output logic              flagRead,
  output logic              flagWrite,
  output logic              flagLong,
  output logic              flagNoResp,
  output logic              flagBusy,
  output logic [31:0]       regRdData
);
  localparam int TXC_W     = $clog2(CMD_LEN);
  localparam int RXC_W     = $clog2(RSP_LONG);
  localparam int CRC_SPAN  = CMD_LEN - CRC_W - 1;
  localparam int RSP_WORDS = RSP_W / 32;

  logic [11:0]         cmdFlags;
  logic [ARG_W-1:0]    argReg;
  logic [TOUT_W-1:0]   toutReg, timer;
  logic [STAT_W-1:0]   status, statSet, statClr;
  logic [CMD_LEN-1:0]  txSh;
  logic [TXC_W-1:0]    txCnt;
  logic [RSP_W-2:0]    rxSh;
  logic [RSP_W-1:0]    shNext;
  logic [RXC_W-1:0]    rxCnt;
  logic [CRC_W-1:0]    rxCrc;
  logic [31:0]         respArr [RSP_WORDS];

  logic wrCmd, wrArg, wrTout, wrStat;
  assign wrCmd  = regWrEn && regAddr == ADDR_W'(A_CMD);
  assign wrArg  = regWrEn && regAddr == ADDR_W'(A_ARG);
  assign wrTout = regWrEn && regAddr == ADDR_W'(A_TOUT);
  assign wrStat = regWrEn && regAddr == ADDR_W'(A_STAT);

  function automatic logic [CRC_W-1:0] frameCrc(input logic [CRC_SPAN-1:0] d);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = CRC_SPAN - 1; i >= 0; i--) c = crcStep(c, d[i]);
    return c;
  endfunction

  logic [CRC_SPAN-1:0] txHead;
  assign txHead = {2'b01, regWrData[IDX_W-1:0], argReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdFlags <= '0;
      argReg   <= '0;
      toutReg  <= '0;
      txSh     <= '1;
      txCnt    <= '0;
    end else begin
      if (wrArg)  argReg  <= regWrData;
      if (wrTout) toutReg <= regWrData[TOUT_W-1:0];
      if (strb.accept) begin
        cmdFlags <= regWrData[11:0];
        txSh     <= {txHead, frameCrc(txHead), 1'b1};
        txCnt    <= '0;
      end else if (strb.shiftTx) begin
        txSh  <= {txSh[CMD_LEN-2:0], 1'b1};
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  assign txBit  = txSh[CMD_LEN-1];
  assign txLast = txCnt == TXC_W'(CMD_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rstN)               timer <= '0;
    else if (strb.loadTimer) timer <= toutReg;
    else if (strb.decTimer)  timer <= timer - 1'b1;
  end
  assign timerZero = timer == '0;

  assign shNext = {rxSh, cmdIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh  <= '0;
      rxCnt <= '0;
      rxCrc <= '0;
    end else if (strb.startRx) begin
      rxSh  <= shNext[RSP_W-2:0];
      rxCnt <= RXC_W'(1);
      rxCrc <= '0;
    end else if (strb.shiftRx) begin
      rxSh  <= shNext[RSP_W-2:0];
      rxCnt <= rxCnt + 1'b1;
      if (rxCnt < RXC_W'(CRC_SPAN)) rxCrc <= crcStep(rxCrc, cmdIn);
    end
  end

  assign rxLast = rxCnt == (flagLong ? RXC_W'(RSP_LONG - 1) : RXC_W'(RSP_SHORT - 1));
  assign crcBad = !flagLong && (rxCrc != shNext[CRC_W:1]);

  for (genvar g = 0; g < RSP_WORDS; g++) begin : gRsp
    logic [31:0] word;
    always_ff @(posedge clk) begin
      if (!rstN) word <= '0;
      else if (strb.storeResp) begin
        if (flagLong)    word <= shNext[g*32 +: 32];
        else if (g == 0) word <= shNext[CRC_SPAN-1:CRC_W+1];
      end
    end
    assign respArr[g] = word;
  end

  always_comb begin
    statSet         = '0;
    statSet[S_FIFO]  = dpEvent[0];
    statSet[S_CRC16] = dpEvent[1];
    statSet[S_RWTO]  = dpEvent[2];
    statSet[S_SDIO]  = dpEvent[3];
    statSet[S_BLK]   = dpEvent[4];
    statSet[S_CRC7]  = strb.flagCrc;
    statSet[S_CTO]   = strb.flagTimeout;
    statSet[S_BUSY]  = strb.flagBusy;
    statClr = wrStat ? regWrData[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~statClr) | statSet;
  end

  assign flagRead   = cmdFlags[6];
  assign flagWrite  = cmdFlags[7];
  assign flagLong   = cmdFlags[9];
  assign flagNoResp = cmdFlags[10];
  assign flagBusy   = cmdFlags[11];

  always_comb begin
    if (regAddr[2]) regRdData = respArr[regAddr[1:0]];
    else unique case (regAddr[1:0])
      2'd0:    regRdData = {16'b0, newBit, failBit, 2'b0, cmdFlags};
      2'd1:    regRdData = argReg;
      2'd2:    regRdData = 32'(toutReg);
      default: regRdData = 32'(status);
    endcase
  end

  // R12
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && regWrData[S_CTO] && !strb.flagTimeout) |=> !status[S_CTO]);

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagTimeout |=> status[S_CTO]);

  // R5
  timer_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.decTimer |=> (timer == $past(timer) - 1'b1));

  // R11
  cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmd && newBit) |=> $stable(cmdFlags));
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int TOUT_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              cmdIn,
  output logic              cmdOut,
  output logic              cmdOe,
  input  logic              dat0In,
  input  logic [4:0]        dpEvent,
  output logic              xferRead,
  output logic              xferWrite,
  output logic              xferBusyWait
);
  strobe_t strb;
  logic newBit, failBit, sending, txBit, txLast, timerZero, rxLast, crcBad;
  logic flagRead, flagWrite, flagLong, flagNoResp, flagBusy, cmdWr;

  assign cmdWr = regWrEn && regAddr == ADDR_W'(A_CMD);

  sdcmd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .reqStart(regWrData[15]),
    .reqLong(regWrData[9]), .reqBusy(regWrData[11]),
    .flagNoResp(flagNoResp), .flagBusy(flagBusy), .txLast(txLast),
    .timerZero(timerZero), .rxLast(rxLast), .crcBad(crcBad),
    .cmdIn(cmdIn), .dat0In(dat0In), .strb(strb), .newBit(newBit),
    .failBit(failBit), .sending(sending)
  );

  sdcmd_dp #(.ADDR_W(ADDR_W), .TOUT_W(TOUT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .cmdIn(cmdIn),
    .dpEvent(dpEvent), .newBit(newBit), .failBit(failBit),
    .txBit(txBit), .txLast(txLast), .timerZero(timerZero),
    .rxLast(rxLast), .crcBad(crcBad), .flagRead(flagRead),
    .flagWrite(flagWrite), .flagLong(flagLong), .flagNoResp(flagNoResp),
    .flagBusy(flagBusy), .regRdData(regRdData)
  );

  assign cmdOe        = sending;
  assign cmdOut       = sending ? txBit : 1'b1;
  assign xferRead     = newBit & flagRead;
  assign xferWrite    = newBit & flagWrite;
  assign xferBusyWait = newBit & flagBusy;
endmodule

// File: tb/sd_cmd_engine_test.sv
module sd_cmd_engine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cmdIn = 1'b1;
  logic        cmdOut, cmdOe;
  logic        dat0In = 1'b1;
  logic [4:0]  dpEvent = '0;
  logic        xferRead, xferWrite, xferBusyWait;

  int errors = 0;
  int checks = 0;
  logic respDone = 1'b0;
  logic [47:0] expQ [$];

  always #10 clk = ~clk;

  sd_cmd_engine uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cmdIn(cmdIn),
    .cmdOut(cmdOut), .cmdOe(cmdOe), .dat0In(dat0In), .dpEvent(dpEvent),
    .xferRead(xferRead), .xferWrite(xferWrite), .xferBusyWait(xferBusyWait)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] refCrc(input logic [39:0] d);
    logic [46:0] v;
    v = {d, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'h89;
    return v[6:0];
  endfunction

  function automatic logic [47:0] mkCmd(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, refCrc({2'b01, idx, arg}), 1'b1};
  endfunction

  function automatic logic [135:0] mkShort(input logic [5:0] idx, input logic [31:0] c);
    return {88'b0, 2'b00, idx, c, refCrc({2'b00, idx, c}), 1'b1};
  endfunction

  // scoreboard monitor: collect each driven frame, compare with queue
  logic [47:0] cap = '0;
  int capN = 0;
  always @(negedge clk) begin
    if (rstN && cmdOe) begin
      cap = {cap[46:0], cmdOut};
      capN++;
      if (capN == 48) begin
        if (expQ.size() == 0) check("R3 unexpected frame", {16'b0, cap}, 64'h0);
        else check("R3 frame", {16'b0, cap}, {16'b0, expQ.pop_front()});
        capN = 0;
      end
    end else begin
      capN = 0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitDone();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd0, v);
      if (!v[15]) break;
    end
  endtask

  task automatic card(input int delay, input int len, input logic [135:0] fr, input int busyN);
    @(negedge clk);
    while (!cmdOe) @(negedge clk);
    while (cmdOe) @(negedge clk);
    if (busyN > 0) dat0In = 1'b0;
    repeat (delay) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      cmdIn = fr[i];
      @(negedge clk);
    end
    cmdIn = 1'b1;
    respDone = 1'b1;
    if (busyN > 0) begin
      repeat (busyN) @(negedge clk);
      dat0In = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [127:0] body;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(3'd0, v); check("R1 cmd reg", v, 0);
    rd(3'd3, v); check("R1 status", v, 0);
    check("R1 line", {cmdOe, cmdOut}, 2'b01);

    // R3/R4 no-response command, CRC anchor frame
    wr(3'd1, 0);
    expQ.push_back(48'h40_0000_0000_95);
    wr(3'd0, 32'h8400);
    repeat (46) @(negedge clk);
    rd(3'd0, v); check("R2 start held", v[15], 1);
    rd(3'd0, v); check("R4 finish timing", v, 32'h0400);

    // R6/R13 short response
    wr(3'd2, 100);
    wr(3'd1, 32'h1234_5678);
    expQ.push_back(mkCmd(17, 32'h1234_5678));
    fork card(2, 48, mkShort(17, 32'hCAFE_F00D), 0); join_none
    wr(3'd0, 32'h8000 | 32'h40 | 17);
    check("R13 read flag active", {xferRead, xferWrite, xferBusyWait}, 3'b100);
    waitDone();
    rd(3'd0, v); check("R6 cmd after short", v, 32'h0051);
    rd(3'd4, v); check("R6 resp0", v, 32'hCAFE_F00D);
    rd(3'd3, v); check("R6 status clean", v, 0);
    check("R13 flags idle", {xferRead, xferWrite, xferBusyWait}, 3'b000);

    // R7 bad CRC
    wr(3'd1, 0);
    expQ.push_back(mkCmd(13, 0));
    fork card(0, 48, mkShort(13, 32'h0000_0900) ^ 136'h2, 0); join_none
    wr(3'd0, 32'h8000 | 13);
    waitDone();
    rd(3'd0, v); check("R7 fail bit", v, 32'h400D);
    rd(3'd3, v); check("R7 crc status", v, 32'h10);
    wr(3'd3, 32'h10);
    rd(3'd3, v); check("R12 w1c clear", v, 0);

    // R5 silent card
    wr(3'd2, 3);
    wr(3'd1, 32'h1AA);
    expQ.push_back(mkCmd(8, 32'h1AA));
    wr(3'd0, 32'h8008);
    waitDone();
    rd(3'd0, v); check("R5 timeout fail", v, 32'h4008);
    rd(3'd3, v); check("R5 timeout status", v, 32'h40);
    wr(3'd3, 32'h40);

    // R5 start at last allowed cycle
    expQ.push_back(mkCmd(8, 32'h1AA));
    fork card(3, 48, mkShort(8, 32'h1AA), 0); join_none
    wr(3'd0, 32'h8008);
    waitDone();
    rd(3'd0, v); check("R5 edge accepted, R2 fail cleared", v, 32'h0008);
    rd(3'd4, v); check("R5 edge resp", v, 32'h1AA);

    // R5 start one cycle too late
    respDone = 1'b0;
    expQ.push_back(mkCmd(8, 32'h1AA));
    fork card(4, 48, mkShort(8, 32'h1AA), 0); join_none
    wr(3'd0, 32'h8008);
    waitDone();
    rd(3'd3, v); check("R5 late start times out", v, 32'h40);
    while (!respDone) @(negedge clk);
    wr(3'd3, 32'h40);

    // R8 long response
    wr(3'd2, 100);
    wr(3'd1, 0);
    body = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEF1;
    expQ.push_back(mkCmd(2, 0));
    fork card(1, 136, {2'b00, 6'h3F, body}, 0); join_none
    wr(3'd0, 32'h8000 | 32'h200 | 2);
    waitDone();
    rd(3'd0, v); check("R8 cmd", v, 32'h0202);
    rd(3'd4, v); check("R8 word0", v, body[31:0]);
    rd(3'd5, v); check("R8 word1", v, body[63:32]);
    rd(3'd6, v); check("R8 word2", v, body[95:64]);
    rd(3'd7, v); check("R8 word3", v, body[127:96]);

    // R10 long + busy rejected
    wr(3'd0, 32'h8000 | 32'h200 | 32'h800 | 9);
    rd(3'd0, v); check("R10 rejected", v, 32'h4A09);
    repeat (5) @(negedge clk);
    check("R10 no drive", cmdOe, 0);

    // R9 busy-wait
    respDone = 1'b0;
    wr(3'd1, 32'h55);
    expQ.push_back(mkCmd(7, 32'h55));
    fork card(1, 48, mkShort(7, 32'h900), 10); join_none
    wr(3'd0, 32'h8000 | 32'h800 | 7);
    check("R13 busy flag", {xferRead, xferWrite, xferBusyWait}, 3'b001);
    while (!respDone) @(negedge clk);
    rd(3'd0, v); check("R9 held while DAT0 low", v, 32'h8807);
    waitDone();
    rd(3'd3, v); check("R9 busy status", v, 32'h400);
    wr(3'd3, 32'h400);

    // R11 write while active ignored
    wr(3'd1, 0);
    expQ.push_back(mkCmd(1, 0));
    wr(3'd0, 32'h8000 | 32'h400 | 32'h80 | 1);
    check("R13 write flag", {xferRead, xferWrite, xferBusyWait}, 3'b010);
    wr(3'd0, 32'h8405);
    waitDone();
    rd(3'd0, v); check("R11 cmd unchanged", v, 32'h0481);
    repeat (60) @(negedge clk);
    check("R11 single frame", expQ.size(), 0);

    // R12 data-path events and set/clear conflict
    @(negedge clk); dpEvent = 5'h1F;
    @(negedge clk); dpEvent = 5'h00;
    rd(3'd3, v); check("R12 event bits", v, 32'h3A8);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd3; regWrData = 32'h200; dpEvent = 5'h10;
    @(negedge clk);
    regWrEn = 1'b0; dpEvent = 5'h00;
    rd(3'd3, v); check("R12 set wins", v, 32'h3A8);
    wr(3'd3, 32'h3A8);
    rd(3'd3, v); check("R12 all cleared", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule